// File: doc/BRIEF.md
# Cipher Engine Register Front-End

This block is the memory-mapped control surface for a DMA-driven block-cipher engine that has two independent command channels, called A and B. Software programs each channel's source address, destination address and byte count, loads a 128-bit key and a 128-bit chaining vector, and then writes a control word with its start bit set. The front-end checks that the addresses and the length are aligned to 16 bytes. It then sends a one-cycle request to the engine, and the start bit remains set for as long as the channel is busy.

When the engine signals done, the start bit clears itself and the channel's completion status bit is raised. A single interrupt word holds three mask bits and three write-one-to-clear status bits. The third status source is a completion pulse from a non-volatile storage controller. The interrupt output is driven from that word. A holding register captures words from an entropy source and flags them as valid until software reads them.

The cipher datapath, the DMA mover and the entropy source are not part of this block. They connect through plain request/done and data/valid ports.

Top module: `cipher_regs`

## Requirements
- R1: After reset, every readable register reads 0, `eng_req` is 0 and `irq` is 0.
- R2: The control word of channel A is at 0x00 and that of channel B is at 0x04. Its bits are: bit0 start/busy, bit1 encrypt, bit2 writable key, bit3 destination coherent, bit4 source coherent, bit5 chained mode, bit6 error. A write with bit0=1 to an idle channel is accepted when its source, destination and length are all multiples of 16. An accepted write produces a one-cycle `eng_req` pulse for that channel in the cycle after the write. Bit0 then reads 1 until done, and bits 5:1 appear on that channel's `eng_mode` field.
- R3: An `eng_done` pulse on a busy channel clears its bit0 and sets that channel's status bit. Channel A uses interrupt-word bit 16 and channel B uses bit 17.
- R4: A start write when a source, destination or length value has any of bits 3:0 set issues no request, leaves bit0 at 0 and sets bit6. A later control write that is accepted or carries no start clears bit6.
- R5: While a channel is busy, writes to its source (A 0x10, B 0x20), destination (0x14/0x24), length (0x18/0x28) and control registers are ignored.
- R6: The interrupt word is at 0x08. Bits 2:0 are read/write masks. Bits 18:16 are status bits; writing 1 to a status bit clears it and writing 0 leaves it unchanged.
- R7: `irq` is 1 exactly when some status bit 16+k is set while mask bit k is 0.
- R8: Key words at 0x30, 0x34, 0x38 and 0x3C drive `key_out` bits 31:0 up to 127:96 in that order, and they read as 0.
- R9: Vector words at 0x40 to 0x4C read back their written values and drive `iv_out` in the same word order as the key.
- R10: An `ent_valid` pulse loads `ent_data` into the holding register at 0x50 only when no unread word is present. Bit0 of 0x54 reads 1 while a word is held, and reading 0x50 clears it.
- R11: An `nv_done` pulse sets status bit 18.
- R12: An `eng_done` pulse on an idle channel has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (used for read side effects) |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| eng_req | output | 2 | One-cycle launch pulse per channel (bit0 = A) |
| eng_done | input | 2 | Completion pulse per channel |
| eng_src | output | 64 | Source address per channel, 32 bits each |
| eng_dst | output | 64 | Destination address per channel |
| eng_len | output | 64 | Byte count per channel |
| eng_mode | output | 10 | Control bits 5:1 per channel, 5 bits each |
| key_out | output | 128 | Writable key |
| iv_out | output | 128 | Chaining vector |
| ent_data | input | 32 | Entropy word |
| ent_valid | input | 1 | Entropy word present |
| nv_done | input | 1 | Storage-controller completion pulse |
| irq | output | 1 | Interrupt request |

## Verification
The most likely failure is a busy flag that is stuck or lost. That would appear in the first control-word read after the expected `eng_done`, as a start bit still set. It would also appear as a missing or extra `eng_req` in the cycle right after the start write. A wrong alignment decision would show as a request where none is due, or as a missing error bit in the same cycle. A corrupted status or mask latch would make `irq` differ from the value computed from the bench's own copy of the interrupt word, one cycle after the event that moved it. An entropy holding flag that is out of step would show on the next status-word read, or as a stale word at 0x50.

// File: rtl/cipher_regs_pkg.sv
package cipher_regs_pkg;
  localparam int unsigned NCH       = 2;
  localparam int unsigned MODE_W    = 5;
  localparam int unsigned CTL_START = 0;
  localparam int unsigned CTL_ERR   = 6;
  localparam int unsigned NSRC      = 3;
  localparam int unsigned STAT_LSB  = 16;

  localparam int unsigned OFF_INT   = 32'h008;
  localparam int unsigned OFF_KEY   = 32'h030;
  localparam int unsigned OFF_IV    = 32'h040;
  localparam int unsigned OFF_RND   = 32'h050;
  localparam int unsigned OFF_RNDST = 32'h054;

  function automatic int unsigned ctl_off(input int unsigned ch);
    return 4 * ch;
  endfunction

  function automatic int unsigned src_off(input int unsigned ch);
    return 32'h010 + 16 * ch;
  endfunction

  // all three transfer parameters must have their low lg2 bits clear
  function automatic logic xfer_ok(input logic [31:0] s, input logic [31:0] d,
                                   input logic [31:0] l, input int unsigned lg2);
    logic [31:0] m;
    m = (32'd1 << lg2) - 32'd1;
    return ((s | d | l) & m) == 32'd0;
  endfunction

  function automatic logic irq_fold(input logic [NSRC-1:0] st, input logic [NSRC-1:0] mk);
    return |(st & ~mk);
  endfunction
endpackage

// File: rtl/cipher_regs_chan.sv
module cipher_regs_chan
  import cipher_regs_pkg::*;
#(
  parameter int unsigned CH        = 0,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned ALIGN_LG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              done,
  output logic              req,
  output logic              busy,
  output logic              accept,
  output logic              reject,
  output logic              finish,
  output logic [31:0]       src_q,
  output logic [31:0]       dst_q,
  output logic [31:0]       len_q,
  output logic [MODE_W-1:0] mode_q,
  output logic              err_q
);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(ctl_off(CH));
  localparam logic [ADDR_W-1:0] A_SRC = ADDR_W'(src_off(CH));
  localparam logic [ADDR_W-1:0] A_DST = ADDR_W'(src_off(CH) + 4);
  localparam logic [ADDR_W-1:0] A_LEN = ADDR_W'(src_off(CH) + 8);

  logic hit_ctl, hit_src, hit_dst, hit_len, go, fits;

  assign hit_ctl = wr && (addr == A_CTL);
  assign hit_src = wr && (addr == A_SRC);
  assign hit_dst = wr && (addr == A_DST);
  assign hit_len = wr && (addr == A_LEN);
  assign go      = hit_ctl && !busy && wdata[CTL_START];
  assign fits    = xfer_ok(src_q, dst_q, len_q, ALIGN_LG2);
  assign accept  = go && fits;
  assign reject  = go && !fits;
  assign finish  = busy && done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req    <= 1'b0;
      busy   <= 1'b0;
      src_q  <= '0;
      dst_q  <= '0;
      len_q  <= '0;
      mode_q <= '0;
      err_q  <= 1'b0;
    end else begin
      req <= accept;
      if (finish)      busy <= 1'b0;
      else if (accept) busy <= 1'b1;
      if (!busy) begin
        if (hit_src) src_q <= wdata;
        if (hit_dst) dst_q <= wdata;
        if (hit_len) len_q <= wdata;
        if (hit_ctl) begin
          mode_q <= wdata[MODE_W:1];
          err_q  <= reject;
        end
      end
    end
  end
endmodule

// File: rtl/cipher_regs_irq.sv
module cipher_regs_irq
  import cipher_regs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [31:0]     wdata,
  input  logic [NSRC-1:0] set,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] stat,
  output logic            irq
);
  logic [NSRC-1:0] clr;

  assign clr = wr ? wdata[STAT_LSB +: NSRC] : '0;
  assign irq = irq_fold(stat, mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask <= '0;
      stat <= '0;
    end else begin
      if (wr) mask <= wdata[NSRC-1:0];
      stat <= (stat & ~clr) | set;
    end
  end
endmodule

// File: rtl/cipher_regs_rng.sv
module cipher_regs_rng (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] ent_data,
  input  logic        ent_valid,
  input  logic        take,
  output logic [31:0] word,
  output logic        full
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
      full <= 1'b0;
    end else if (take) begin
      full <= 1'b0;
    end else if (ent_valid && !full) begin
      word <= ent_data;
      full <= 1'b1;
    end
  end
endmodule

// File: rtl/cipher_regs.sv
module cipher_regs
  import cipher_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned ALIGN_LG2 = 4,
  parameter int unsigned KEY_W     = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        eng_req,
  input  logic [1:0]        eng_done,
  output logic [63:0]       eng_src,
  output logic [63:0]       eng_dst,
  output logic [63:0]       eng_len,
  output logic [9:0]        eng_mode,
  output logic [KEY_W-1:0]  key_out,
  output logic [KEY_W-1:0]  iv_out,
  input  logic [31:0]       ent_data,
  input  logic              ent_valid,
  input  logic              nv_done,
  output logic              irq
);
  localparam int unsigned KEY_WORDS = KEY_W / 32;

  logic [NCH-1:0]  busy_w, acc_w, rej_w, fin_w, err_w;
  logic [NSRC-1:0] int_mask, int_stat;
  logic            int_hit, rng_take, rng_full;
  logic [31:0]     rng_word;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cipher_regs_chan #(.CH(c), .ADDR_W(ADDR_W), .ALIGN_LG2(ALIGN_LG2)) u_ch (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .done(eng_done[c]), .req(eng_req[c]), .busy(busy_w[c]), .accept(acc_w[c]),
      .reject(rej_w[c]), .finish(fin_w[c]),
      .src_q(eng_src[32*c +: 32]), .dst_q(eng_dst[32*c +: 32]),
      .len_q(eng_len[32*c +: 32]), .mode_q(eng_mode[MODE_W*c +: MODE_W]),
      .err_q(err_w[c])
    );
  end

  for (genvar w = 0; w < KEY_WORDS; w++) begin : g_word
    logic [31:0] kq, vq;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        kq <= '0;
        vq <= '0;
      end else if (bus_wr) begin
        if (bus_addr == ADDR_W'(OFF_KEY + 4 * w)) kq <= bus_wdata;
        if (bus_addr == ADDR_W'(OFF_IV + 4 * w))  vq <= bus_wdata;
      end
    end
    assign key_out[32*w +: 32] = kq;
    assign iv_out[32*w +: 32]  = vq;
  end

  assign int_hit  = bus_wr && (bus_addr == ADDR_W'(OFF_INT));
  assign rng_take = bus_rd && (bus_addr == ADDR_W'(OFF_RND));

  cipher_regs_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr(int_hit), .wdata(bus_wdata),
    .set({nv_done, fin_w}), .mask(int_mask), .stat(int_stat), .irq(irq)
  );

  cipher_regs_rng u_rng (
    .clk(clk), .rst_n(rst_n), .ent_data(ent_data), .ent_valid(ent_valid),
    .take(rng_take), .word(rng_word), .full(rng_full)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFF_INT)) begin
      bus_rdata[NSRC-1:0]          = int_mask;
      bus_rdata[STAT_LSB +: NSRC]  = int_stat;
    end
    if (bus_addr == ADDR_W'(OFF_RND))   bus_rdata = rng_word;
    if (bus_addr == ADDR_W'(OFF_RNDST)) bus_rdata = {31'd0, rng_full};
    for (int unsigned c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(ctl_off(c))) begin
        bus_rdata[CTL_START]       = busy_w[c];
        bus_rdata[MODE_W:1]        = eng_mode[MODE_W*c +: MODE_W];
        bus_rdata[CTL_ERR]         = err_w[c];
      end
      if (bus_addr == ADDR_W'(src_off(c)))     bus_rdata = eng_src[32*c +: 32];
      if (bus_addr == ADDR_W'(src_off(c) + 4)) bus_rdata = eng_dst[32*c +: 32];
      if (bus_addr == ADDR_W'(src_off(c) + 8)) bus_rdata = eng_len[32*c +: 32];
    end
    for (int unsigned w = 0; w < KEY_WORDS; w++) begin
      if (bus_addr == ADDR_W'(OFF_IV + 4 * w)) bus_rdata = iv_out[32*w +: 32];
    end
  end
endmodule

module cipher_regs_chk
  import cipher_regs_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NCH-1:0]  eng_req,
  input logic [NCH-1:0]  busy,
  input logic [NCH-1:0]  acc,
  input logic [NCH-1:0]  rej,
  input logic [NCH-1:0]  fin,
  input logic [NCH-1:0]  err,
  input logic [NSRC-1:0] stat,
  input logic            irq,
  input logic [63:0]     eng_len,
  input logic [63:0]     eng_src,
  input logic            rng_full,
  input logic            rng_take,
  input logic [31:0]     rng_word
);
  for (genvar i = 0; i < NCH; i++) begin : g_p
    // R2
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_req[i] |=> !eng_req[i]);
    // R2
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc[i] |=> eng_req[i] && busy[i]);
    // R4
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rej[i] |=> !eng_req[i] && !busy[i] && err[i]);
    // R3
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin[i] |=> !busy[i] && stat[i]);
    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy[i] && $past(busy[i]) |-> $stable(eng_len[32*i +: 32]) && $stable(eng_src[32*i +: 32]));
  end
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat != '0);
  // R10
  rng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rng_full && !rng_take |=> rng_full && $stable(rng_word));
endmodule

bind cipher_regs cipher_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_req(eng_req), .busy(busy_w), .acc(acc_w),
  .rej(rej_w), .fin(fin_w), .err(err_w), .stat(int_stat), .irq(irq),
  .eng_len(eng_len), .eng_src(eng_src), .rng_full(rng_full),
  .rng_take(rng_take), .rng_word(rng_word)
);

// File: tb/sim_cipher_regs.sv
module sim_cipher_regs;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, bus_wr, bus_rd, ent_valid, nv_done, irq;
  logic [11:0]  bus_addr;
  logic [31:0]  bus_wdata, bus_rdata, ent_data;
  logic [1:0]   eng_req, eng_done;
  logic [63:0]  eng_src, eng_dst, eng_len;
  logic [9:0]   eng_mode;
  logic [127:0] key_out, iv_out;

  int n_cmp = 0;
  int n_bad = 0;

  cipher_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_req(eng_req), .eng_done(eng_done),
    .eng_src(eng_src), .eng_dst(eng_dst), .eng_len(eng_len), .eng_mode(eng_mode),
    .key_out(key_out), .iv_out(iv_out), .ent_data(ent_data), .ent_valid(ent_valid),
    .nv_done(nv_done), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic eng_finish(input int unsigned ch);
    @(negedge clk); eng_done[ch] = 1'b1;
    @(negedge clk); eng_done = 2'b00;
  endtask

  task automatic pulse_ent(input logic [31:0] d);
    @(negedge clk); ent_valid = 1'b1; ent_data = d;
    @(negedge clk); ent_valid = 1'b0;
  endtask

  // bench view of alignment: a value is usable when it divides evenly by 16
  function automatic logic aligned3(input logic [31:0] s, input logic [31:0] d, input logic [31:0] l);
    return (s % 16 == 0) && (d % 16 == 0) && (l % 16 == 0);
  endfunction

  function automatic logic [31:0] ctl_view(input logic err, input logic [4:0] m, input logic st);
    return {25'd0, err, m, st};
  endfunction

  function automatic logic [31:0] rnd_field();
    logic [31:0] v;
    v = {12'd0, 16'($urandom_range(0, 65535)), 4'd0};
    if ($urandom_range(0, 5) == 0) v[3:0] = 4'($urandom_range(1, 15));
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd4711));
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    eng_done = 2'b00; ent_valid = 1'b0; ent_data = '0; nv_done = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h000, r); chk("R1 ctl A", r, 0);
    rd(12'h008, r); chk("R1 int word", r, 0);
    rd(12'h054, r); chk("R1 rng status", r, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 eng_req", {30'd0, eng_req}, 0);

    // R8 key words
    wr(12'h030, 32'h11111111); wr(12'h034, 32'h22222222);
    wr(12'h038, 32'h33333333); wr(12'h03C, 32'h44444444);
    rd(12'h030, r); chk("R8 key read zero", r, 0);
    rd(12'h03C, r); chk("R8 key read zero", r, 0);
    chk("R8 key word0", key_out[31:0], 32'h11111111);
    chk("R8 key word3", key_out[127:96], 32'h44444444);

    // R9 vector words
    wr(12'h040, 32'hA0A0A0A0); wr(12'h04C, 32'hD3D3D3D3);
    rd(12'h040, r); chk("R9 iv word0", r, 32'hA0A0A0A0);
    rd(12'h04C, r); chk("R9 iv word3", r, 32'hD3D3D3D3);
    chk("R9 iv_out word3", iv_out[127:96], 32'hD3D3D3D3);

    // R2 accepted start on channel A
    wr(12'h010, 32'h1000); wr(12'h014, 32'h2000); wr(12'h018, 32'h40);
    wr(12'h000, 32'h23);
    chk("R2 req pulse A", {30'd0, eng_req}, 32'd1);
    chk("R2 mode A", {27'd0, eng_mode[4:0]}, 32'h11);
    rd(12'h000, r); chk("R2 busy readback", r, 32'h23);
    chk("R2 req single cycle", {30'd0, eng_req}, 0);

    // R5 writes ignored while busy
    wr(12'h018, 32'h80); wr(12'h000, 32'h0);
    rd(12'h018, r); chk("R5 len held", r, 32'h40);
    rd(12'h000, r); chk("R5 ctl held", r, 32'h23);

    // R12 done on idle channel B
    eng_finish(1);
    rd(12'h008, r); chk("R12 idle done ignored", r, 0);

    // R3 completion of A
    eng_finish(0);
    rd(12'h000, r); chk("R3 start cleared", r, 32'h22);
    rd(12'h008, r); chk("R3 status A bit16", r, 32'h10000);
    chk("R7 irq unmasked", {31'd0, irq}, 1);

    // R6 / R7 mask and write-one-to-clear
    wr(12'h008, 32'h1);
    chk("R7 irq masked", {31'd0, irq}, 0);
    rd(12'h008, r); chk("R6 status kept under mask", r, 32'h10001);
    wr(12'h008, 32'h10000);
    rd(12'h008, r); chk("R6 status cleared", r, 0);

    // R4 misaligned length on channel B
    wr(12'h020, 32'h3000); wr(12'h024, 32'h4000); wr(12'h028, 32'h44);
    wr(12'h004, 32'h1);
    chk("R4 no req", {30'd0, eng_req}, 0);
    rd(12'h004, r); chk("R4 err bit", r, 32'h40);
    wr(12'h028, 32'h40); wr(12'h004, 32'h3);
    chk("R4 retry accepted", {30'd0, eng_req}, 32'd2);
    rd(12'h004, r); chk("R4 err cleared", r, 32'h3);
    eng_finish(1);
    rd(12'h008, r); chk("R3 status B bit17", r, 32'h20000);
    wr(12'h008, 32'h20000);

    // R11 storage completion
    @(negedge clk); nv_done = 1'b1; @(negedge clk); nv_done = 1'b0;
    rd(12'h008, r); chk("R11 status bit18", r, 32'h40000);
    chk("R11 irq", {31'd0, irq}, 1);
    wr(12'h008, 32'h40000);
    chk("R7 irq idle", {31'd0, irq}, 0);

    // R10 entropy holding
    pulse_ent(32'hDEADBEEF);
    rd(12'h054, r); chk("R10 valid set", r, 1);
    pulse_ent(32'h12345678);
    rd(12'h050, r); chk("R10 first word kept", r, 32'hDEADBEEF);
    rd(12'h054, r); chk("R10 valid cleared", r, 0);
    pulse_ent(32'h0BADF00D);
    rd(12'h050, r); chk("R10 next word", r, 32'h0BADF00D);

    // random start attempts
    for (int it = 0; it < 40; it++) begin
      int unsigned ch;
      logic [31:0] s, d, l, cw;
      logic good;
      ch = $urandom_range(0, 1);
      s = rnd_field(); d = rnd_field(); l = rnd_field();
      cw = {26'd0, 5'($urandom_range(0, 31)), 1'b1};
      good = aligned3(s, d, l);
      wr(12'(16 + 16 * ch), s); wr(12'(20 + 16 * ch), d); wr(12'(24 + 16 * ch), l);
      wr(12'(4 * ch), cw);
      chk("R2 R4 random req", {30'd0, eng_req}, good ? (32'd1 << ch) : 32'd0);
      if (good) begin
        chk("R2 random mode", {27'd0, eng_mode[5*ch +: 5]}, {27'd0, cw[5:1]});
        rd(12'(4 * ch), r); chk("R2 random busy", r, ctl_view(1'b0, cw[5:1], 1'b1));
        wr(12'(24 + 16 * ch), l + 32'h10);
        rd(12'(24 + 16 * ch), r); chk("R5 random len held", r, l);
        eng_finish(ch);
        rd(12'(4 * ch), r); chk("R3 random done", r, ctl_view(1'b0, cw[5:1], 1'b0));
        chk("R7 random irq", {31'd0, irq}, 1);
        wr(12'h008, 32'h30000);
        chk("R6 random clear", {31'd0, irq}, 0);
      end else begin
        rd(12'(4 * ch), r); chk("R4 random reject", r, ctl_view(1'b1, cw[5:1], 1'b0));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule